// File: doc/BRIEF.md
# Data Access Translation and Protection Unit

This block turns the virtual address of a load or store into a physical address, or into a fault code and a memory-management status word. It runs a fixed chain of checks in this order: access alignment, the physical-mode bypass, virtual address validity, the kernel-only superpage window, the TLB hit or miss, and finally the per-mode read/write permission and fault-on-access bits of the hit entry.

The TLB itself lives outside the block. The unit drives the virtual page number and the address-space number to it as combinational outputs. The TLB returns its hit flag, page frame and permission bits in the same cycle. The result is registered, so it appears one cycle after the request together with a done strobe. Single-cycle event pulses for hits, misses and protection violations are provided for external counters.

Top module: `dx_xlate_unit`

## Requirements
- R1: A request with `req_valid` high produces `done` high on the next clock edge, with results held until the next request. `done` is low in every cycle that does not follow a request, and after reset all outputs are zero.
- R2: Access size is encoded as log2 of the byte count (0=1 byte .. 3=8 bytes). If any of the low (size) address bits are set, the unit reports fault 1 (alignment). This takes precedence over every other check, and the status word holds only the write bit.
- R3: The status word has these bits: bit0 store, bit1 access violation, bit2 fault-on-read, bit3 fault-on-write, bit4 TLB miss, bit5 bad virtual address. Any fault reports physical address 0. A fault-free result reports status 0.
- R4: In physical mode (`req_phys`=1) with an aligned address, the physical address is the low 44 address bits. No other check applies.
- R5: A virtual address is valid only when bits 63:43 are all zeros or all ones. Otherwise the unit reports fault 2 (page fault) with status bits 5 and 1, plus bit0 for a store.
- R6: A valid address with bits 47:41 equal to 0x7e is a superpage. Modes are encoded kernel=0, executive=1, supervisor=2, user=3. Outside kernel mode a superpage access gives fault 3 (access violation) with status bit1, plus bit0 for a store.
- R7: A kernel superpage access bypasses the TLB. Its physical address is VA bits 39:0, with bits 43:40 all ones when VA bit 40 is set and all zeros otherwise.
- R8: On a TLB miss the unit reports fault 4, or fault 5 when `req_pte` marks a page-table-entry fetch. The status is bit4, plus bit0 for a store.
- R9: On a TLB hit with no fault, the physical address is the page frame number shifted left by 13 plus VA bits 12:0.
- R10: A store to a hit entry whose write-enable mask lacks bit (mode) gives fault 2 with status bits 0 and 1, plus bit3 if the entry's fault-on-write flag is set. A permitted store to an entry with fault-on-write set gives fault 2 with status bits 0 and 3.
- R11: A load to a hit entry whose read-enable mask lacks bit (mode) gives fault 3 with status bit1, plus bit2 if fault-on-read is set. A permitted load with fault-on-read set gives fault 2 with status bit2.
- R12: Together with `done`, at most one event pulses. `ev_hit` pulses for a fault-free TLB-translated access, `ev_miss` for faults 4 and 5, and `ev_viol` for faults 2 and 3.
- R13: `lk_vpn` always equals VA bits 42:13 and `lk_asn` always equals `cur_asn`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Access size, log2 bytes |
| req_write | input | 1 | 1 = store, 0 = load |
| req_phys | input | 1 | Physical-mode request |
| req_pte | input | 1 | Request is a page-table-entry fetch |
| cur_mode | input | 2 | Current privilege mode |
| cur_asn | input | 8 | Current address-space number |
| lk_vpn | output | 30 | Virtual page number to the TLB |
| lk_asn | output | 8 | Address-space number to the TLB |
| tlb_hit | input | 1 | TLB hit flag |
| tlb_ppn | input | 31 | Page frame number of the hit entry |
| tlb_rd_mask | input | 4 | Read enable, one bit per mode |
| tlb_wr_mask | input | 4 | Write enable, one bit per mode |
| tlb_for | input | 1 | Entry fault-on-read flag |
| tlb_fow | input | 1 | Entry fault-on-write flag |
| done | output | 1 | Result valid strobe |
| pa | output | 44 | Physical address |
| fault | output | 3 | Fault code |
| mm_stat | output | 6 | Memory-management status word |
| ev_hit | output | 1 | Hit event pulse |
| ev_miss | output | 1 | Miss event pulse |
| ev_viol | output | 1 | Violation event pulse |

## Verification
The TLB lookup outputs are combinational. The bench checks them one time step after driving the address, before any clock edge. Every other result passes through exactly one register. The bench therefore drives each request at a falling edge and reads `pa`, `fault`, `mm_stat`, `done` and the events at the next falling edge, half a period after the capturing rising edge. It then checks that `done` and the events are low one cycle after the request is withdrawn.

// File: rtl/dx_pkg.sv
package dx_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ALIGN    = 3'd1,
    FLT_PAGE     = 3'd2,
    FLT_ACV      = 3'd3,
    FLT_MISS     = 3'd4,
    FLT_PTE_MISS = 3'd5
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FOR   = 2;
  localparam int ST_FOW   = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

  localparam int MODE_KERNEL = 0;
endpackage

// File: rtl/dx_addr_check.sv
module dx_addr_check #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int SIZE_W  = 2,
  parameter int SP_HI   = 47,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 'h7e
) (
  input  logic [VA_W-1:0]   va,
  input  logic [SIZE_W-1:0] size,
  output logic              misaligned,
  output logic              va_bad,
  output logic              is_super
);
  localparam int AL_W = (1 << SIZE_W) - 1;
  localparam int SP_W = SP_HI - SP_LO + 1;

  logic [AL_W-1:0] al_mask;
  logic [VA_W-VA_IMPL-1:0] hi_bits;

  always_comb begin
    for (int i = 0; i < AL_W; i++) al_mask[i] = (i < int'(size));
  end

  assign hi_bits    = va[VA_W-1:VA_IMPL];
  assign misaligned = |(va[AL_W-1:0] & al_mask);
  assign va_bad     = !((&hi_bits) || !(|hi_bits));
  assign is_super   = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
endmodule

// File: rtl/dx_perm_check.sv
module dx_perm_check
  import dx_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic                   write,
  input  logic [MODE_W-1:0]      mode,
  input  logic [(1<<MODE_W)-1:0] rd_mask,
  input  logic [(1<<MODE_W)-1:0] wr_mask,
  input  logic                   fo_rd,
  input  logic                   fo_wr,
  output fault_e                 p_fault,
  output logic [ST_W-1:0]        p_stat
);
  logic allowed, fo_hit;

  assign allowed = write ? wr_mask[mode] : rd_mask[mode];
  assign fo_hit  = write ? fo_wr : fo_rd;

  always_comb begin
    p_fault = FLT_NONE;
    p_stat  = '0;
    if (!allowed) begin
      p_fault         = write ? FLT_PAGE : FLT_ACV;
      p_stat[ST_WR]   = write;
      p_stat[ST_ACV]  = 1'b1;
      p_stat[ST_FOW]  = write & fo_wr;
      p_stat[ST_FOR]  = !write & fo_rd;
    end else if (fo_hit) begin
      p_fault         = FLT_PAGE;
      p_stat[ST_WR]   = write;
      p_stat[ST_FOW]  = write;
      p_stat[ST_FOR]  = !write;
    end
  end
endmodule

// File: rtl/dx_sp_map.sv
module dx_sp_map #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int SP_EXT = 40
) (
  input  logic [VA_W-1:0] va,
  output logic [PA_W-1:0] sp_pa
);
  assign sp_pa = {{(PA_W-SP_EXT){va[SP_EXT]}}, va[SP_EXT-1:0]};
endmodule

// File: rtl/dx_xlate_unit.sv
module dx_xlate_unit
  import dx_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int PG_BITS = 13,
  parameter int ASN_W   = 8,
  parameter int SIZE_W  = 2,
  parameter int MODE_W  = 2,
  parameter int SP_HI   = 47,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 'h7e,
  parameter int SP_EXT  = 40,
  localparam int NMODES = 1 << MODE_W,
  localparam int PPN_W  = PA_W - PG_BITS,
  localparam int VPN_W  = VA_IMPL - PG_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_va,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic                req_write,
  input  logic                req_phys,
  input  logic                req_pte,
  input  logic [MODE_W-1:0]   cur_mode,
  input  logic [ASN_W-1:0]    cur_asn,
  output logic [VPN_W-1:0]    lk_vpn,
  output logic [ASN_W-1:0]    lk_asn,
  input  logic                tlb_hit,
  input  logic [PPN_W-1:0]    tlb_ppn,
  input  logic [NMODES-1:0]   tlb_rd_mask,
  input  logic [NMODES-1:0]   tlb_wr_mask,
  input  logic                tlb_for,
  input  logic                tlb_fow,
  output logic                done,
  output logic [PA_W-1:0]     pa,
  output logic [2:0]          fault,
  output logic [ST_W-1:0]     mm_stat,
  output logic                ev_hit,
  output logic                ev_miss,
  output logic                ev_viol
);
  logic misaligned, va_bad, is_super;
  logic [PA_W-1:0] sp_pa, pa_n;
  fault_e perm_f, f_n;
  logic [ST_W-1:0] perm_st, st_n;
  logic tlb_ok;

  assign lk_vpn = req_va[VA_IMPL-1:PG_BITS];
  assign lk_asn = cur_asn;

  dx_addr_check #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SIZE_W(SIZE_W),
    .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
  ) u_addr (
    .va(req_va), .size(req_size),
    .misaligned(misaligned), .va_bad(va_bad), .is_super(is_super)
  );

  dx_sp_map #(.VA_W(VA_W), .PA_W(PA_W), .SP_EXT(SP_EXT)) u_sp (
    .va(req_va), .sp_pa(sp_pa)
  );

  dx_perm_check #(.MODE_W(MODE_W)) u_perm (
    .write(req_write), .mode(cur_mode),
    .rd_mask(tlb_rd_mask), .wr_mask(tlb_wr_mask),
    .fo_rd(tlb_for), .fo_wr(tlb_fow),
    .p_fault(perm_f), .p_stat(perm_st)
  );

  // Checks in fixed priority order
  always_comb begin
    f_n    = FLT_NONE;
    st_n   = '0;
    pa_n   = '0;
    tlb_ok = 1'b0;
    if (misaligned) begin
      f_n          = FLT_ALIGN;
      st_n[ST_WR]  = req_write;
    end else if (req_phys) begin
      pa_n = req_va[PA_W-1:0];
    end else if (va_bad) begin
      f_n            = FLT_PAGE;
      st_n[ST_WR]    = req_write;
      st_n[ST_ACV]   = 1'b1;
      st_n[ST_BADVA] = 1'b1;
    end else if (is_super) begin
      if (cur_mode != MODE_W'(MODE_KERNEL)) begin
        f_n          = FLT_ACV;
        st_n[ST_WR]  = req_write;
        st_n[ST_ACV] = 1'b1;
      end else begin
        pa_n = sp_pa;
      end
    end else if (!tlb_hit) begin
      f_n           = req_pte ? FLT_PTE_MISS : FLT_MISS;
      st_n[ST_WR]   = req_write;
      st_n[ST_MISS] = 1'b1;
    end else begin
      f_n    = perm_f;
      st_n   = perm_st;
      tlb_ok = (perm_f == FLT_NONE);
      if (tlb_ok) pa_n = {tlb_ppn, req_va[PG_BITS-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      pa      <= '0;
      fault   <= '0;
      mm_stat <= '0;
      ev_hit  <= 1'b0;
      ev_miss <= 1'b0;
      ev_viol <= 1'b0;
    end else begin
      done    <= req_valid;
      ev_hit  <= req_valid && tlb_ok;
      ev_miss <= req_valid && (f_n == FLT_MISS || f_n == FLT_PTE_MISS);
      ev_viol <= req_valid && (f_n == FLT_PAGE || f_n == FLT_ACV);
      if (req_valid) begin
        pa      <= pa_n;
        fault   <= f_n;
        mm_stat <= st_n;
      end
    end
  end
endmodule

// File: rtl/dx_xlate_chk.sv
module dx_xlate_chk #(
  parameter int VA_W = 64,
  parameter int PA_W = 44
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic [1:0]      req_size,
  input logic            req_write,
  input logic            req_phys,
  input logic            done,
  input logic [PA_W-1:0] pa,
  input logic [2:0]      fault,
  input logic [5:0]      mm_stat,
  input logic            ev_hit,
  input logic            ev_miss,
  input logic            ev_viol
);
  logic [2:0] al_mask;
  logic       mis;
  assign al_mask = 3'((4'd1 << req_size) - 4'd1);
  assign mis     = |(req_va[2:0] & al_mask);

  p_done_lat_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done);
  p_align_first_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mis) |=> (fault == 3'd1 && mm_stat == {5'b0, $past(req_write)}));
  p_fault_pa_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 3'd0) |-> (pa == '0));
  p_clean_stat_r3: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 3'd0) |-> (mm_stat == '0));
  p_phys_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_phys && !mis) |=> (fault == 3'd0 && pa == $past(req_va[PA_W-1:0])));
  p_miss_stat_r8: assert property (@(posedge clk) disable iff (rst)
    (done && (fault == 3'd4 || fault == 3'd5)) |-> mm_stat[4]);
  p_ev_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_hit, ev_miss, ev_viol}));
  p_ev_with_done_r12: assert property (@(posedge clk) disable iff (rst)
    (ev_hit || ev_miss || ev_viol) |-> done);
endmodule

bind dx_xlate_unit dx_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
  .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
  .done(done), .pa(pa), .fault(fault), .mm_stat(mm_stat),
  .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_viol(ev_viol)
);

// File: tb/dx_xlate_unit_tb.sv
module dx_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_phys = 1'b0, req_pte = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic [7:0]  cur_asn = '0;
  logic [29:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        tlb_hit = 1'b0;
  logic [30:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_mask = '0, tlb_wr_mask = '0;
  logic        tlb_for = 1'b0, tlb_fow = 1'b0;
  logic        done;
  logic [43:0] pa;
  logic [2:0]  fault;
  logic [5:0]  mm_stat;
  logic        ev_hit, ev_miss, ev_viol;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dx_xlate_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
    .req_pte(req_pte), .cur_mode(cur_mode), .cur_asn(cur_asn),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_rd_mask(tlb_rd_mask), .tlb_wr_mask(tlb_wr_mask),
    .tlb_for(tlb_for), .tlb_fow(tlb_fow), .done(done), .pa(pa),
    .fault(fault), .mm_stat(mm_stat), .ev_hit(ev_hit),
    .ev_miss(ev_miss), .ev_viol(ev_viol)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference behaviour built from the requirement list
  task automatic model(output logic [2:0] ef, output logic [5:0] es,
                       output logic [43:0] ep, output logic [2:0] eev,
                       output string tag);
    logic [2:0] m;
    logic [20:0] hi;
    m  = 3'((4'd1 << req_size) - 4'd1);
    hi = req_va[63:43];
    ef = 3'd0; es = '0; ep = '0; eev = 3'b000;
    if ((req_va[2:0] & m) != 0) begin
      ef = 3'd1; es[0] = req_write; tag = "R2";
    end else if (req_phys) begin
      ep = req_va[43:0]; tag = "R4";
    end else if (!(hi == '0 || hi == '1)) begin
      ef = 3'd2; es = {1'b1, 3'b000, 1'b1, req_write}; tag = "R5";
    end else if (req_va[47:41] == 7'h7e) begin
      if (cur_mode != 2'd0) begin
        ef = 3'd3; es = {4'b0000, 1'b1, req_write}; tag = "R6";
      end else begin
        ep = req_va[40] ? {4'hf, req_va[39:0]} : {4'h0, req_va[39:0]};
        tag = "R7";
      end
    end else if (!tlb_hit) begin
      ef = req_pte ? 3'd5 : 3'd4; es = {1'b0, 1'b1, 3'b000, req_write}; tag = "R8";
    end else if (req_write) begin
      tag = "R10";
      if (!tlb_wr_mask[cur_mode]) begin
        ef = 3'd2; es = {2'b00, tlb_fow, 1'b0, 2'b11};
      end else if (tlb_fow) begin
        ef = 3'd2; es = 6'b001001;
      end else begin
        ep = {tlb_ppn, req_va[12:0]}; tag = "R9";
      end
    end else begin
      tag = "R11";
      if (!tlb_rd_mask[cur_mode]) begin
        ef = 3'd3; es = {3'b000, tlb_for, 2'b10};
      end else if (tlb_for) begin
        ef = 3'd2; es = 6'b000100;
      end else begin
        ep = {tlb_ppn, req_va[12:0]}; tag = "R9";
      end
    end
    if (ef == 3'd0 && tag == "R9") eev = 3'b100;
    else if (ef == 3'd4 || ef == 3'd5) eev = 3'b010;
    else if (ef == 3'd2 || ef == 3'd3) eev = 3'b001;
  endtask

  // Drive at a falling edge, read one clock later at the next falling edge
  task automatic run_req;
    logic [2:0] ef; logic [5:0] es; logic [43:0] ep; logic [2:0] eev;
    string tag;
    req_valid = 1'b1;
    #1;
    check(lk_vpn == req_va[42:13] && lk_asn == cur_asn, "R13 lookup",
          {26'b0, lk_asn, lk_vpn}, {26'b0, cur_asn, req_va[42:13]});
    model(ef, es, ep, eev, tag);
    @(negedge clk);
    check(done && fault == ef && mm_stat == es && pa == ep, {tag, " result"},
          {7'b0, done, fault, mm_stat, pa}, {7'b0, 1'b1, ef, es, ep});
    check({ev_hit, ev_miss, ev_viol} == eev, {"R12 events ", tag},
          {61'b0, ev_hit, ev_miss, ev_viol}, {61'b0, eev});
    req_valid = 1'b0;
  endtask

  localparam logic [63:0] BASE = 64'h0000_0012_3456_A000;

  initial begin
    repeat (3) @(negedge clk);
    check(!done && pa == 0 && fault == 0 && mm_stat == 0 &&
          !ev_hit && !ev_miss && !ev_viol, "R1 reset state",
          {7'b0, done, fault, mm_stat, pa}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // Alignment sweep with a fully permitted hit entry (R2, R9)
    tlb_hit = 1'b1; tlb_rd_mask = 4'hf; tlb_wr_mask = 4'hf; tlb_ppn = 31'h1abc;
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        for (int w = 0; w < 2; w++) begin
          req_size = 2'(s); req_va = BASE + 64'(o); req_write = w[0];
          run_req();
        end

    // Alignment beats bad VA and physical mode (R2)
    req_size = 2'd3; req_va = 64'h0100_0000_0000_0004; req_phys = 1'b1;
    run_req();
    req_phys = 1'b0;
    run_req();

    // Physical mode ignores bad VA, superpage and mode (R4)
    req_size = 2'd0; req_phys = 1'b1; cur_mode = 2'd3; tlb_hit = 1'b0;
    req_va = 64'h0100_0ABC_DEF0_1235; run_req();
    req_va = 64'hFFFF_FD23_4567_89AB; run_req();
    req_phys = 1'b0;

    // Invalid virtual addresses (R5)
    for (int w = 0; w < 2; w++) begin
      req_write = w[0];
      req_va = 64'h0000_0800_0000_0000; run_req();
      req_va = 64'h8000_0000_0000_0000; run_req();
      req_va = 64'hFFFF_F7FF_FFFF_FFF0; run_req();
    end

    // Superpage over all modes, both bit-40 values (R6, R7)
    for (int md = 0; md < 4; md++)
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 2; w++) begin
          cur_mode = 2'(md); req_write = w[0];
          req_va = 64'hFFFF_FC00_0000_0000 | (64'(b) << 40) | 64'h00AB_CDEF_1230;
          run_req();
        end

    // TLB misses (R8)
    cur_mode = 2'd2; tlb_hit = 1'b0;
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++) begin
        req_pte = p[0]; req_write = w[0]; req_va = BASE + 64'h18; run_req();
      end
    req_pte = 1'b0;

    // Permission sweep: modes x masks x fault-on flag x direction (R9-R11)
    tlb_hit = 1'b1;
    for (int md = 0; md < 4; md++)
      for (int mk = 0; mk < 16; mk++)
        for (int fo = 0; fo < 2; fo++)
          for (int w = 0; w < 2; w++) begin
            cur_mode = 2'(md); req_write = w[0];
            tlb_rd_mask = 4'(mk); tlb_wr_mask = 4'(mk ^ 5);
            tlb_for = fo[0]; tlb_fow = fo[0];
            tlb_ppn = 31'(mk * 977 + md);
            cur_asn = 8'(mk * 16 + md);
            req_va = 64'hFFFF_FFF0_0000_0000 | 64'(mk * 8192 + md * 8);
            run_req();
          end

    // Idle cycle after a request: no done, no events (R1, R12)
    @(negedge clk);
    check(!done && !ev_hit && !ev_miss && !ev_viol, "R1 idle done low",
          {60'b0, done, ev_hit, ev_miss, ev_viol}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule